// File: doc/BRIEF.md
# Bit-Serial Two-Operand Adder

This unit adds two unsigned WIDTH-bit operands one bit position per clock. It uses one full adder and a carry flip-flop. A single-cycle `go` request captures both operands in parallel. The unit then walks through them from the least significant bit upward and collects each sum bit in a result register. When every bit position has been processed, it raises `done` together with the final carry. The result stays on the outputs until the next request, so a host can start an addition and later read `sum` and `cout` at any time once `done` is high.

Three named states steer the datapath:

- **ST_IDLE**: the operand registers hold and the adder is frozen.
- **ST_LOAD**: the operand registers capture `op_a` and `op_b`. The adder's enable line is driven low, which clears its carry, bit counter, result, `done` and `cout`.
- **ST_SHIFT**: the operand registers shift right by one each clock and the adder takes one step per clock.

The transitions are:

- **idle→load**: taken when `go` is sampled high.
- **load→shift**: always taken after one cycle.
- **shift→idle**: taken once the adder reports `done`.
- In every other case the state holds.

The operand registers take a select code: hold = 2'b00, parallel load = 2'b01, shift right = 2'b10.

Top module: `serial_add_unit`

## Requirements
- R1: After `rst` is asserted (asynchronous, active high), the controller is in ST_IDLE and `sum`, `cout` and `done` are all 0.
- R2: When `go` is sampled high in ST_IDLE, the next state is ST_LOAD and both operands are captured from `op_a`/`op_b` at that load edge.
- R3: The ST_LOAD edge clears `done`, `cout` and `sum` to zero, so `done` reads 0 one clock after the edge that sampled `go`.
- R4: After completion, `sum` equals (`op_a` + `op_b`) mod 2^WIDTH and `cout` equals bit WIDTH of the (WIDTH+1)-bit sum. This holds for all-zero, all-one, all-ones-plus-one and random operands.
- R5: `done` first reads 1 exactly WIDTH+2 clock edges after the edge that sampled `go`, and reads 0 at every edge before that.
- R6: While an addition is in progress (ST_LOAD or ST_SHIFT), `go` and changes on `op_a`/`op_b` have no effect on the result or its timing.
- R7: Once `done` is seen in ST_SHIFT, the controller returns to ST_IDLE. In ST_IDLE, `sum`, `cout` and `done` stay unchanged even when `op_a`/`op_b` change, until the next `go`.
- R8: ST_LOAD is always followed by ST_SHIFT. A new `go` after completion starts a fresh addition whose result replaces the previous one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Asynchronous active-high reset |
| go | input | 1 | Start request, sampled in ST_IDLE |
| op_a | input | WIDTH | First operand, captured at load |
| op_b | input | WIDTH | Second operand, captured at load |
| sum | output | WIDTH | Result, valid when `done` is 1 |
| cout | output | 1 | Carry out of the most significant bit |
| done | output | 1 | Completion flag, held until the next load |

## Verification
The bench builds the unit with WIDTH = 8. At that width an all-ones operand, a carry rippling through every position, and the exact WIDTH+2 cycle completion window are all short enough to check edge by edge. Random 8-bit operand pairs exercise mixed carry patterns against a (WIDTH+1)-bit reference sum. An 8-cycle shift phase leaves room to inject a stray `go` and changed operands in the middle of an addition.

// File: rtl/sadd_pkg.sv
package sadd_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_SHIFT = 2'd2
    } ctrl_st_t;

    // Operand register select codes
    typedef enum logic [1:0] {
        SEL_NOP   = 2'b00,
        SEL_LOAD  = 2'b01,
        SEL_SHIFT = 2'b10
    } reg_sel_t;

endpackage

// File: rtl/opnd_shreg.sv
module opnd_shreg
    import sadd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  reg_sel_t     sel,
    input  logic [W-1:0] din,
    output logic         lsb
);

    logic [W-1:0] q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            q <= '0;
        end else begin
            case (sel)
                SEL_LOAD:  q <= din;
                SEL_SHIFT: q <= {1'b0, q[W-1:1]};
                default:   q <= q;
            endcase
        end
    end

    assign lsb = q[0];

endmodule

// File: rtl/bit_adder.sv
module bit_adder #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,      // low = synchronous clear
    input  logic         step,    // high = advance one bit
    input  logic         a_bit,
    input  logic         b_bit,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         done
);

    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(W);

    logic          carry_q;
    logic [CW-1:0] cnt_q;
    logic [W-1:0]  sum_q;
    logic          cout_q;
    logic          done_q;
    logic          s_bit;
    logic          c_nxt;

    // One-bit full adder
    always_comb begin
        s_bit = a_bit ^ b_bit ^ carry_q;
        c_nxt = (a_bit & b_bit) | (a_bit & carry_q) | (b_bit & carry_q);
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            carry_q <= 1'b0;
            cnt_q   <= '0;
            sum_q   <= '0;
            cout_q  <= 1'b0;
            done_q  <= 1'b0;
        end else if (!en) begin
            carry_q <= 1'b0;
            cnt_q   <= '0;
            sum_q   <= '0;
            cout_q  <= 1'b0;
            done_q  <= 1'b0;
        end else if (step) begin
            if (cnt_q != CNT_LAST) begin
                carry_q <= c_nxt;
                cnt_q   <= cnt_q + 1'b1;
                sum_q   <= {s_bit, sum_q[W-1:1]};
            end else if (!done_q) begin
                done_q  <= 1'b1;
                cout_q  <= carry_q;
                carry_q <= 1'b0;
            end
        end
    end

    assign sum  = sum_q;
    assign cout = cout_q;
    assign done = done_q;

endmodule

// File: rtl/sadd_ctrl.sv
module sadd_ctrl
    import sadd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     go,
    input  logic     add_done,
    output reg_sel_t sel,
    output logic     add_en,
    output logic     add_step,
    output ctrl_st_t state
);

    ctrl_st_t st_q;
    ctrl_st_t st_d;

    // State register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (go) st_d = ST_LOAD;
            ST_LOAD:  st_d = ST_SHIFT;
            ST_SHIFT: if (add_done) st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        sel      = SEL_NOP;
        add_en   = 1'b1;
        add_step = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                sel      = SEL_NOP;
                add_en   = 1'b1;
                add_step = 1'b0;
            end
            ST_LOAD: begin
                sel      = SEL_LOAD;
                add_en   = 1'b0;
                add_step = 1'b0;
            end
            ST_SHIFT: begin
                sel      = SEL_SHIFT;
                add_en   = 1'b1;
                add_step = 1'b1;
            end
            default: begin
                sel      = SEL_NOP;
                add_en   = 1'b1;
                add_step = 1'b0;
            end
        endcase
    end

    assign state = st_q;

endmodule

// File: rtl/serial_add_unit.sv
module serial_add_unit
    import sadd_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             done
);

    localparam int NOPS = 2;

    reg_sel_t                    sel;
    logic                        add_en;
    logic                        add_step;
    ctrl_st_t                    ctl_state;
    logic [NOPS-1:0][WIDTH-1:0]  par_in;
    logic [NOPS-1:0]             bit_out;

    assign par_in[0] = op_a;
    assign par_in[1] = op_b;

    sadd_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .go       (go),
        .add_done (done),
        .sel      (sel),
        .add_en   (add_en),
        .add_step (add_step),
        .state    (ctl_state)
    );

    for (genvar g = 0; g < NOPS; g++) begin : g_opnd
        opnd_shreg #(.W(WIDTH)) u_reg (
            .clk (clk),
            .rst (rst),
            .sel (sel),
            .din (par_in[g]),
            .lsb (bit_out[g])
        );
    end

    bit_adder #(.W(WIDTH)) u_add (
        .clk   (clk),
        .rst   (rst),
        .en    (add_en),
        .step  (add_step),
        .a_bit (bit_out[0]),
        .b_bit (bit_out[1]),
        .sum   (sum),
        .cout  (cout),
        .done  (done)
    );

endmodule

// File: rtl/sadd_checker.sv
module sadd_checker
    import sadd_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             go,
    input ctrl_st_t         st,
    input logic [WIDTH-1:0] sum,
    input logic             cout,
    input logic             done
);

    a_r2_go_to_load: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && go) |=> (st == ST_LOAD));

    a_r3_load_clears: assert property (@(posedge clk) disable iff (rst)
        (st == ST_LOAD) |=> (!done && !cout && sum == '0));

    a_r5_done_in_shift: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (st == ST_SHIFT));

    a_r6_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SHIFT && !done) |=> (st == ST_SHIFT));

    a_r7_idle_stable: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |=> ($stable(sum) && $stable(cout) && $stable(done)));

    a_r7_done_exit: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SHIFT && done) |=> (st == ST_IDLE));

    a_r8_load_then_shift: assert property (@(posedge clk) disable iff (rst)
        (st == ST_LOAD) |=> (st == ST_SHIFT));

endmodule

bind serial_add_unit sadd_checker #(.WIDTH(WIDTH)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .go   (go),
    .st   (ctl_state),
    .sum  (sum),
    .cout (cout),
    .done (done)
);

// File: tb/sim_serial_add_unit.sv
module sim_serial_add_unit;

    localparam int W       = 8;
    localparam time CLK_PER = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         go  = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic [W-1:0] sum;
    logic         cout;
    logic         done;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PER / 2) clk = ~clk;

    serial_add_unit #(.WIDTH(W)) u0 (
        .clk (clk), .rst (rst), .go (go),
        .op_a (op_a), .op_b (op_b),
        .sum (sum), .cout (cout), .done (done)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // R1: reset state
    task automatic t_reset();
        rst = 1'b1;
        go  = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 sum after reset", longint'(sum), 0);
        check("R1 cout after reset", longint'(cout), 0);
        check("R1 done after reset", longint'(done), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 done idle after release", longint'(done), 0);
        check("R1 sum idle after release", longint'(sum), 0);
    endtask

    // R2 R3 R4 R5 R6 R8: one addition, optional stray go while busy
    task automatic t_add(input logic [W-1:0] a, input logic [W-1:0] b,
                         input bit poke, input string tag);
        logic [W:0] expv;
        expv = {1'b0, a} + {1'b0, b};
        @(negedge clk);
        op_a = a;
        op_b = b;
        go   = 1'b1;
        @(negedge clk);            // edge 0 sampled go
        go = 1'b0;
        for (int k = 1; k <= W + 2; k++) begin
            if (poke && k == 3) begin
                go   = 1'b1;       // R6 stray request
                op_a = ~a;
                op_b = b ^ {W{1'b1}};
            end
            @(negedge clk);
            if (poke && k == 3) go = 1'b0;
            if (k == 1) begin
                check({"R3 done cleared by load ", tag}, longint'(done), 0);
                check({"R3 cout cleared by load ", tag}, longint'(cout), 0);
            end
            check({"R5 done timing ", tag}, longint'(done), (k == W + 2) ? 1 : 0);
        end
        check({"R4 sum ", tag}, longint'(sum), longint'(expv[W-1:0]));
        check({"R4 cout ", tag}, longint'(cout), longint'(expv[W]));
    endtask

    // R7: outputs hold in idle while operands change
    task automatic t_idle_hold();
        logic [W-1:0] s0;
        logic         c0;
        s0 = sum;
        c0 = cout;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            op_a = W'(k * 37 + 5);
            op_b = W'(k * 91 + 1);
        end
        check("R7 sum held in idle", longint'(sum), longint'(s0));
        check("R7 cout held in idle", longint'(cout), longint'(c0));
        check("R7 done held in idle", longint'(done), 1);
    endtask

    initial begin
        t_reset();
        t_add('0, '0, 1'b0, "zeros");
        t_add({W{1'b1}}, {W{1'b1}}, 1'b0, "all ones");
        t_add({W{1'b1}}, W'(1), 1'b0, "ones plus one");
        t_idle_hold();
        t_add(W'(8'h5a), W'(8'h3c), 1'b1, "busy go R6");
        t_add(W'(8'h01), W'(8'h02), 1'b0, "back to back R8");
        for (int i = 0; i < 20; i++) begin
            t_add(W'($urandom), W'($urandom), (i % 4) == 0, "random");
        end
        t_idle_hold();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PER * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule